// File: doc/BRIEF.md
# Instruction-Set Switch Branch Checker

This block judges a branch that moves the core from its native instruction set into a legacy 32-bit instruction set. A request strobe brings in the branch operands. These are the qualifying-predicate index, the 64-bit branch-register target, the processor status word, the code-segment base and limit, a 16-bit segment flag, a segment privilege-violation flag and a dirty-register-stack flag. The block answers one cycle later.

The answer says whether the branch itself faults. If it does, the answer carries a ranked fault code and the branch has no architectural effect. Otherwise the branch proceeds, and the block returns the following:
- the legacy instruction pointer;
- the deferred faults that will be charged to the first legacy instruction;
- the updated status word;
- a strobe that clears the current register stack frame.

The block holds the legacy resume flag unchanged until a separate strobe reports that the first legacy instruction has completed.

Top module: `xset_branch_check`

## Requirements
- R1: `vld_o` is high for exactly the one cycle after a cycle with `req_i` high, and low otherwise.
- R2: `bfault_o` ranks the branch faults. It is 1 when `qp_i` is not 0. Otherwise it is 2 when status bit 1 (transition disable) is set. Otherwise it is 3 when `dirty_stack_i` is high. Otherwise it is 0.
- R3: When `bfault_o` is not 0, the branch makes no change. `ok_o`, `frame_zero_o`, `gp_fault_o` and `fp_fault_o` are 0, and `status_o` equals the request's `status_i`.
- R4: `eip_o` equals target bits [31:0] minus `seg_base_i`, modulo 2^32.
- R5: On a branch that proceeds, `gp_fault_o` is 1 when `eip_o` is greater than `seg_limit_i` or `seg_priv_err_i` is high. The branch still proceeds (`ok_o`=1).
- R6: On a branch that proceeds with `seg16_i` high, `gp_fault_o` is also 1 when `eip_o` is 0x10000 or more.
- R7: On a branch that proceeds, `fp_fault_o` equals status bit 2 (FP registers disabled).
- R8: On a branch that proceeds, `ok_o` and `frame_zero_o` are 1. In `status_o`, bit 0 (legacy mode) is set and bits [7:3] are cleared. Bits 1, 2 and [10:8] (privilege level and register bank) are unchanged.
- R9: `iip_o` equals the full 64-bit target of the request.
- R10: `rf_o` loads `rf_i` on each request. After a branch that proceeds, `rf_o` holds until `first_done_i` is seen, and then it clears. `first_done_i` has no effect when no switched branch is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Branch evaluation request |
| qp_i | input | 6 | Qualifying-predicate index |
| target_i | input | 64 | Branch-register target |
| status_i | input | 11 | Processor status word |
| seg_base_i | input | 32 | Code-segment base |
| seg_limit_i | input | 32 | Code-segment limit |
| seg16_i | input | 1 | Target segment is 16-bit |
| seg_priv_err_i | input | 1 | Segment privilege violation |
| dirty_stack_i | input | 1 | Register stack holds dirty registers |
| rf_i | input | 1 | Current legacy resume flag |
| first_done_i | input | 1 | First legacy instruction completed |
| vld_o | output | 1 | Result valid |
| bfault_o | output | 2 | Branch fault code |
| ok_o | output | 1 | Switch committed |
| gp_fault_o | output | 1 | Deferred general-protection fault |
| fp_fault_o | output | 1 | Deferred disabled-FP fault |
| eip_o | output | 32 | Legacy instruction pointer |
| status_o | output | 11 | Updated status word |
| frame_zero_o | output | 1 | Clear current register frame |
| iip_o | output | 64 | Interruption IP for branch traps |
| rf_o | output | 1 | Legacy resume flag |

## Verification
The hardest cases to reach are the address boundaries. They are a pointer equal to the limit against one past it, a pointer of 0xFFFF against 0x10000 in a 16-bit segment, and a target below the base, where the subtraction wraps. The bench reaches each one by choosing the target's low word as the base plus a fixed offset. It then sweeps every combination of predicate, disable, dirty, FP, 16-bit and privilege inputs over those four address patterns. The resume-flag hold is a separate case. Completion strobes are sent before any switch and after a faulted branch, and neither may clear the flag.

// File: rtl/xset_pkg.sv
package xset_pkg;
  localparam int ST_W       = 11;
  localparam int ST_LEGACY  = 0;
  localparam int ST_XDIS    = 1;
  localparam int ST_FPDIS   = 2;
  localparam int ST_SHOT_LO = 3;
  localparam int ST_SHOT_HI = 7;

  typedef enum logic [1:0] {
    BF_NONE  = 2'd0,
    BF_PRED  = 2'd1,
    BF_XDIS  = 2'd2,
    BF_DIRTY = 2'd3
  } bfault_e;
endpackage

// File: rtl/xset_fault_rank.sv
module xset_fault_rank
  import xset_pkg::*;
#(
  parameter int QP_W = 6
) (
  input  logic [QP_W-1:0] qp_i,
  input  logic            xdis_i,
  input  logic            dirty_i,
  output bfault_e         code_o
);
  localparam int NF = 3;
  logic [NF-1:0] hit;
  logic [NF-1:0] sel;

  assign hit = {dirty_i, xdis_i, (qp_i != '0)};

  // lowest index wins
  for (genvar g = 0; g < NF; g++) begin : g_rank
    if (g == 0) begin : g_first
      assign sel[g] = hit[g];
    end else begin : g_rest
      assign sel[g] = hit[g] & ~|hit[g-1:0];
    end
  end

  always_comb begin
    unique case (1'b1)
      sel[0]:  code_o = BF_PRED;
      sel[1]:  code_o = BF_XDIS;
      sel[2]:  code_o = BF_DIRTY;
      default: code_o = BF_NONE;
    endcase
  end
endmodule

// File: rtl/xset_target_chk.sv
module xset_target_chk #(
  parameter int ADDR_W = 32,
  parameter int SPAN_W = 16
) (
  input  logic [ADDR_W-1:0] tgt_lo_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic              seg16_i,
  input  logic              priv_err_i,
  output logic [ADDR_W-1:0] eip_o,
  output logic              gp_o
);
  logic over_limit;
  logic over_span;

  assign eip_o      = tgt_lo_i - base_i;
  assign over_limit = eip_o > limit_i;
  assign over_span  = seg16_i & (|eip_o[ADDR_W-1:SPAN_W]);
  assign gp_o       = priv_err_i | over_limit | over_span;
endmodule

// File: rtl/xset_status_fold.sv
module xset_status_fold
  import xset_pkg::*;
(
  input  logic [ST_W-1:0] st_i,
  output logic [ST_W-1:0] st_o
);
  for (genvar b = 0; b < ST_W; b++) begin : g_bit
    if (b == ST_LEGACY) begin : g_set
      assign st_o[b] = 1'b1;
    end else if (b >= ST_SHOT_LO && b <= ST_SHOT_HI) begin : g_clr
      assign st_o[b] = 1'b0;
    end else begin : g_keep
      assign st_o[b] = st_i[b];
    end
  end
endmodule

// File: rtl/xset_branch_check.sv
module xset_branch_check
  import xset_pkg::*;
#(
  parameter int QP_W   = 6,
  parameter int TGT_W  = 64,
  parameter int ADDR_W = 32,
  parameter int SPAN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [QP_W-1:0]   qp_i,
  input  logic [TGT_W-1:0]  target_i,
  input  logic [ST_W-1:0]   status_i,
  input  logic [ADDR_W-1:0] seg_base_i,
  input  logic [ADDR_W-1:0] seg_limit_i,
  input  logic              seg16_i,
  input  logic              seg_priv_err_i,
  input  logic              dirty_stack_i,
  input  logic              rf_i,
  input  logic              first_done_i,
  output logic              vld_o,
  output logic [1:0]        bfault_o,
  output logic              ok_o,
  output logic              gp_fault_o,
  output logic              fp_fault_o,
  output logic [ADDR_W-1:0] eip_o,
  output logic [ST_W-1:0]   status_o,
  output logic              frame_zero_o,
  output logic [TGT_W-1:0]  iip_o,
  output logic              rf_o
);
  bfault_e           code;
  logic [ADDR_W-1:0] eip_c;
  logic              gp_c;
  logic [ST_W-1:0]   st_ok;
  logic              pass;

  xset_fault_rank #(.QP_W(QP_W)) u_rank (
    .qp_i   (qp_i),
    .xdis_i (status_i[ST_XDIS]),
    .dirty_i(dirty_stack_i),
    .code_o (code)
  );

  xset_target_chk #(.ADDR_W(ADDR_W), .SPAN_W(SPAN_W)) u_tgt (
    .tgt_lo_i  (target_i[ADDR_W-1:0]),
    .base_i    (seg_base_i),
    .limit_i   (seg_limit_i),
    .seg16_i   (seg16_i),
    .priv_err_i(seg_priv_err_i),
    .eip_o     (eip_c),
    .gp_o      (gp_c)
  );

  xset_status_fold u_fold (
    .st_i(status_i),
    .st_o(st_ok)
  );

  assign pass = (code == BF_NONE);

  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o        <= 1'b0;
      bfault_o     <= '0;
      ok_o         <= 1'b0;
      gp_fault_o   <= 1'b0;
      fp_fault_o   <= 1'b0;
      eip_o        <= '0;
      status_o     <= '0;
      frame_zero_o <= 1'b0;
      iip_o        <= '0;
    end else begin
      vld_o <= req_i;
      if (req_i) begin
        bfault_o     <= code;
        ok_o         <= pass;
        gp_fault_o   <= pass & gp_c;
        fp_fault_o   <= pass & status_i[ST_FPDIS];
        eip_o        <= eip_c;
        status_o     <= pass ? st_ok : status_i;
        frame_zero_o <= pass;
        iip_o        <= target_i;
      end else begin
        frame_zero_o <= 1'b0;
      end
    end
  end

  // resume flag: held until first legacy instruction completes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rf_o   <= 1'b0;
      pend_q <= 1'b0;
    end else if (req_i) begin
      rf_o   <= rf_i;
      pend_q <= pass;
    end else if (first_done_i && pend_q) begin
      rf_o   <= 1'b0;
      pend_q <= 1'b0;
    end
  end

  AST_VLD_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> vld_o) else $error("vld"); // R1
  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !vld_o) else $error("vld pulse"); // R1
  AST_FAULT_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && bfault_o != 2'd0) |-> (!ok_o && !frame_zero_o && !gp_fault_o && !fp_fault_o))
    else $error("commit on fault"); // R3
  AST_COMMIT_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && ok_o) |-> (status_o[ST_LEGACY] && status_o[ST_SHOT_HI:ST_SHOT_LO] == '0))
    else $error("status"); // R8
  AST_PRIV_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> status_o[ST_W-1:ST_SHOT_HI+1] == $past(status_i[ST_W-1:ST_SHOT_HI+1]))
    else $error("priv"); // R8
  AST_IIP_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> iip_o == $past(target_i)) else $error("iip"); // R9
  AST_RF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && !first_done_i) |=> $stable(rf_o)) else $error("rf"); // R10
endmodule

// File: tb/xset_branch_check_bench.sv
module xset_branch_check_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [5:0]  qp_i = '0;
  logic [63:0] target_i = '0;
  logic [10:0] status_i = '0;
  logic [31:0] seg_base_i = '0;
  logic [31:0] seg_limit_i = '0;
  logic        seg16_i = 1'b0;
  logic        seg_priv_err_i = 1'b0;
  logic        dirty_stack_i = 1'b0;
  logic        rf_i = 1'b0;
  logic        first_done_i = 1'b0;
  logic        vld_o, ok_o, gp_fault_o, fp_fault_o, frame_zero_o, rf_o;
  logic [1:0]  bfault_o;
  logic [31:0] eip_o;
  logic [10:0] status_o;
  logic [63:0] iip_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  xset_branch_check u_xset_branch_check (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_case(input logic [5:0] qp, input logic [63:0] tgt, input logic [10:0] st,
                          input logic [31:0] base, input logic [31:0] lim, input logic s16,
                          input logic perr, input logic dirty);
    logic [1:0]  e_code;
    logic [31:0] e_eip;
    logic        e_pass, e_gp;
    logic [10:0] e_st;
    @(negedge clk_i);
    qp_i = qp; target_i = tgt; status_i = st; seg_base_i = base; seg_limit_i = lim;
    seg16_i = s16; seg_priv_err_i = perr; dirty_stack_i = dirty; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    e_code = (qp != 0) ? 2'd1 : st[1] ? 2'd2 : dirty ? 2'd3 : 2'd0;
    e_pass = (e_code == 2'd0);
    e_eip  = tgt[31:0] - base;
    e_gp   = e_pass && (perr || e_eip > lim || (s16 && e_eip >= 32'h10000));
    e_st   = e_pass ? {st[10:8], 5'b0, st[2:1], 1'b1} : st;
    chk("R1 vld", vld_o, 1);
    chk("R2 code", bfault_o, e_code);
    chk("R3/R8 ok", ok_o, e_pass);
    chk("R3/R8 frame", frame_zero_o, e_pass);
    chk("R3/R8 status", status_o, e_st);
    chk("R4 eip", eip_o, e_eip);
    chk("R5/R6 gp", gp_fault_o, e_gp);
    chk("R7 fp", fp_fault_o, e_pass && st[2]);
    chk("R9 iip", iip_o, tgt);
    @(negedge clk_i);
    chk("R1 vld pulse", vld_o, 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] base, lo, lim;
    repeat (2) @(negedge clk_i);
    chk("R1 reset vld", vld_o, 0);
    chk("R10 reset rf", rf_o, 0);
    chk("R8 reset frame", frame_zero_o, 0);
    rst_ni = 1'b1;
    for (int p = 0; p < 4; p++) begin
      case (p)
        0: begin base = 32'h1000; lo = 32'h1000 + 32'hFFFF;  lim = 32'hFFFF;     end
        1: begin base = 32'h1000; lo = 32'h1000 + 32'h10000; lim = 32'hFFFFF;    end
        2: begin base = 32'h2000; lo = 32'h1000;             lim = 32'hFFFFFFFF; end
        default: begin base = 32'h0; lo = 32'h501;           lim = 32'h500;      end
      endcase
      for (int m = 0; m < 64; m++) begin
        run_case((m[0] ? 6'd5 : 6'd0) | (m[0] && p == 3 ? 6'd63 : 6'd0),
                 {32'hDEAD_BEEF ^ {26'd0, m[5:0]}, lo},
                 {3'b101, 5'b11011, m[2], m[1], 1'b0},
                 base, lim, m[4], m[5], m[3]);
      end
    end
    // R10 resume flag handling
    @(negedge clk_i); first_done_i = 1'b1;
    @(negedge clk_i); first_done_i = 1'b0;
    run_case(6'd0, 64'h0000_0001_0000_2000, 11'h0F8, 32'h1000, 32'hFFFF, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i); rf_i = 1'b1; req_i = 1'b1; status_i = 11'h002;
    @(negedge clk_i); req_i = 1'b0;
    chk("R10 rf load on faulted", rf_o, 1);
    @(negedge clk_i); first_done_i = 1'b1;
    @(negedge clk_i); first_done_i = 1'b0;
    chk("R10 done ignored w/o pending", rf_o, 1);
    @(negedge clk_i); status_i = 11'h000; req_i = 1'b1;
    @(negedge clk_i); req_i = 1'b0;
    chk("R10 rf load on switch", rf_o, 1);
    repeat (3) @(negedge clk_i);
    chk("R10 rf held", rf_o, 1);
    first_done_i = 1'b1;
    @(negedge clk_i); first_done_i = 1'b0;
    chk("R10 rf cleared", rf_o, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule